// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits between a serial-bus protocol controller and the storage array of a byte-wide nonvolatile memory model. The controller hands it a starting address, then the data bytes of one write transaction, then a commit request when the transaction closes. The block gathers those bytes into a one-page buffer and then writes them into the array together, in one timed programming cycle.

Only the low offset bits of the address advance from byte to byte. A transaction that sends more than a page of data therefore wraps around inside the same page, and the later bytes replace the earlier ones. Each buffer slot keeps a flag that marks it as received, so only bytes that actually arrived are written. Bytes that did not arrive keep their old contents in the array.

A write-protect input is sampled at the first data byte. A build parameter chooses whether protection covers the lowest or the highest quarter of the address space. A refused first byte rejects the whole transaction. The programming time is modelled by a clock-cycle count, and the busy flag stays high for exactly that count. The array itself is external and is reached through a synchronous write port.

Top module: `pcw_page_writer`

## Requirements
- R1: A pulse on `addr_load` while idle opens a transaction. The page base becomes `addr_in[12:6]` and the write offset becomes `addr_in[5:0]`. The load also clears the set of received bytes and any earlier rejection.
- R2: Each accepted byte is stored at the current offset. The offset then advances by one modulo 64, and the page base never changes. A 65th byte lands on the slot of the first byte and replaces it.
- R3: The cycle after a `byte_stb` pulse that falls in an open transaction while idle, `ack_vld` is 1 for one cycle. `ack_ok` is then 1 if the byte was stored and 0 if it was refused. A strobe while no transaction is open gives no `ack_vld`.
- R4: When the sampled protect level is 1, some addresses are protected. With `GUARD_SIDE` = 0, these are the addresses whose two top bits are 00. With `GUARD_SIDE` = 1, they are the addresses whose two top bits are 11. When the sampled level is 0, nothing is protected. The array never receives a write to a protected address.
- R5: `wp` is sampled when the first data byte of a transaction arrives. Changes to `wp` later in the same transaction have no effect.
- R6: If the first data byte falls in a protected quarter, that byte and every later byte of the transaction are refused. The commit request then starts no write cycle.
- R7: A commit request for a transaction that received no data bytes leaves `busy` low and writes nothing.
- R8: A valid commit raises `busy` in the next cycle and keeps it high for exactly `WRITE_CYCLES` cycles. Every commit request closes the transaction, so a second commit request starts nothing.
- R9: During the write cycle, each received byte is written exactly once to address {page base, offset}. No other address is written.
- R10: While `busy` is high, `addr_load`, `byte_stb` and `commit_req` are ignored. They produce no acknowledge, no array write and no change to the page being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Open a transaction at `addr_in` |
| addr_in | input | ADDR_W | Starting byte address |
| byte_stb | input | 1 | One data byte is present on `byte_in` |
| byte_in | input | DATA_W | Data byte |
| commit_req | input | 1 | Transaction closed; commit the buffered page |
| wp | input | 1 | Write-protect level |
| busy | output | 1 | Write cycle in progress |
| ack_vld | output | 1 | Verdict for the previous strobe is valid |
| ack_ok | output | 1 | 1 = byte stored, 0 = refused |
| ram_we | output | 1 | Array write enable |
| ram_addr | output | ADDR_W | Array write address |
| ram_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume that the controller asserts at most one of `addr_load`, `byte_stb` and `commit_req` in any cycle, and that each of them is a single-cycle pulse. The bench drives every stimulus through tasks that raise exactly one of these strobes for one cycle. The bench changes `wp` only together with a byte strobe, and it raises the strobes during a write cycle only in the dedicated test that checks they are ignored.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic {GUARD_LOW = 1'b0, GUARD_HIGH = 1'b1} guard_e;

  // true when the quarter (two top address bits) is the one guarded by side
  function automatic logic in_guard(guard_e side, logic [1:0] quarter);
    return (side == GUARD_LOW) ? (quarter == 2'b00) : (quarter == 2'b11);
  endfunction
endpackage

// File: rtl/pcw_page_store.sv
module pcw_page_store #(
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_hit
);
  localparam int PAGE = 1 << PAGE_BITS;

  logic [DATA_W-1:0] mem [PAGE];
  logic [PAGE-1:0]   vld;

  // plain synchronous write / registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_hit <= 1'b0;
    end else begin
      if (clr)        vld         <= '0;
      else if (wr_en) vld[wr_idx] <= 1'b1;
      rd_hit <= vld[rd_idx];
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld == '0)) else $error("received set not cleared"); // R1
endmodule

// File: rtl/pcw_guard.sv
module pcw_guard
  import pcw_pkg::*;
#(
  parameter int     ADDR_W = 13,
  parameter guard_e SIDE   = GUARD_LOW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_level,
  output logic              blocked
);
  assign blocked = wp_level && in_guard(SIDE, addr[ADDR_W-1 -: 2]);
endmodule

// File: rtl/pcw_cycle_timer.sv
module pcw_cycle_timer #(
  parameter int CYCLES    = 5000,
  parameter int PAGE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 scan_on,
  output logic [PAGE_BITS-1:0] scan_idx
);
  // CYCLES must exceed the page size so the scan ends inside the busy window
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int CW   = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST  = CW'(CYCLES - 1);
  localparam logic [CW-1:0] PAGEC = CW'(PAGE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign scan_on  = busy && (cnt < PAGEC);
  assign scan_idx = cnt[PAGE_BITS-1:0];

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt) == LAST) else $error("busy window length"); // R8
endmodule

// File: rtl/pcw_page_writer.sv
module pcw_page_writer
  import pcw_pkg::*;
#(
  parameter int     ADDR_W       = 13,
  parameter int     DATA_W       = 8,
  parameter int     PAGE_BITS    = 6,
  parameter int     WRITE_CYCLES = 5000,
  parameter guard_e GUARD_SIDE   = GUARD_LOW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              commit_req,
  input  logic              wp,
  output logic              busy,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  logic                 open_q, have_q, rej_q, wph_q;
  logic [HI_W-1:0]      base_q;
  logic [PAGE_BITS-1:0] off_q, idx_d;
  logic                 scan_d;

  logic                 idle, load, stb, close, start, accept;
  logic                 wp_eff, blocked;
  logic                 scan_on, rd_hit;
  logic [PAGE_BITS-1:0] scan_idx;
  logic [DATA_W-1:0]    rd_data;

  assign idle   = !busy;
  assign load   = addr_load && idle;
  assign stb    = byte_stb && idle && open_q && !addr_load;
  assign close  = commit_req && idle && !addr_load;
  assign start  = close && open_q && have_q && !rej_q;
  assign wp_eff = have_q ? wph_q : wp;
  assign accept = stb && !rej_q && !blocked;

  pcw_guard #(.ADDR_W(ADDR_W), .SIDE(GUARD_SIDE)) u_guard (
    .addr({base_q, off_q}), .wp_level(wp_eff), .blocked(blocked)
  );

  pcw_page_store #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_store (
    .clk(clk), .rst(rst), .clr(load),
    .wr_en(accept), .wr_idx(off_q), .wr_data(byte_in),
    .rd_idx(scan_idx), .rd_data(rd_data), .rd_hit(rd_hit)
  );

  pcw_cycle_timer #(.CYCLES(WRITE_CYCLES), .PAGE_BITS(PAGE_BITS)) u_timer (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .scan_on(scan_on), .scan_idx(scan_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      have_q  <= 1'b0;
      rej_q   <= 1'b0;
      wph_q   <= 1'b0;
      base_q  <= '0;
      off_q   <= '0;
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
      scan_d  <= 1'b0;
      idx_d   <= '0;
    end else begin
      ack_vld <= stb;
      ack_ok  <= accept;
      scan_d  <= scan_on;
      idx_d   <= scan_idx;
      if (load) begin
        base_q <= addr_in[ADDR_W-1:PAGE_BITS];
        off_q  <= addr_in[PAGE_BITS-1:0];
        open_q <= 1'b1;
        have_q <= 1'b0;
        rej_q  <= 1'b0;
      end else begin
        if (stb) begin
          have_q <= 1'b1;
          if (!have_q) wph_q <= wp;
          if (!have_q && blocked) rej_q <= 1'b1;
          if (accept) off_q <= off_q + 1'b1;
        end
        if (close) open_q <= 1'b0;
      end
    end
  end

  assign ram_we    = scan_d && rd_hit;
  assign ram_addr  = {base_q, idx_d};
  assign ram_wdata = rd_data;

  AST_GUARD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ram_we && wph_q) |-> !in_guard(GUARD_SIDE, ram_addr[ADDR_W-1 -: 2])) else $error("protected write"); // R4
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !busy && rej_q) |=> !busy) else $error("rejected commit ran"); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !busy && !have_q) |=> !busy) else $error("empty commit ran"); // R7
  AST_ACK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(byte_stb && !busy)) else $error("stray acknowledge"); // R3
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(base_q)) else $error("page moved while busy"); // R10
endmodule

// File: tb/pcw_page_writer_test.sv
module pcw_page_writer_test;
  import pcw_pkg::*;
  localparam int WC = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        addr_load = 0, byte_stb = 0, commit_req = 0, wp = 0;
  logic [12:0] addr_in = '0;
  logic [7:0]  byte_in = '0;
  logic [1:0]  busy_v, ackv_v, acko_v, we_v;
  logic [12:0] wa_v [2];
  logic [7:0]  wd_v [2];

  pcw_page_writer #(.WRITE_CYCLES(WC), .GUARD_SIDE(GUARD_LOW)) uut (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .commit_req(commit_req), .wp(wp),
    .busy(busy_v[0]), .ack_vld(ackv_v[0]), .ack_ok(acko_v[0]),
    .ram_we(we_v[0]), .ram_addr(wa_v[0]), .ram_wdata(wd_v[0]));

  pcw_page_writer #(.WRITE_CYCLES(WC), .GUARD_SIDE(GUARD_HIGH)) uut_hi (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .commit_req(commit_req), .wp(wp),
    .busy(busy_v[1]), .ack_vld(ackv_v[1]), .ack_ok(acko_v[1]),
    .ram_we(we_v[1]), .ram_addr(wa_v[1]), .ram_wdata(wd_v[1]));

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] dut_mem [int];
  logic [7:0] exp_mem [int];
  int dut_wr [2];
  int exp_wr [2];

  // bench model, one per variant
  logic [7:0] m_buf [2][64];
  logic       m_val [2][64];
  logic       m_open [2], m_have [2], m_rej [2], m_busy [2];
  logic [6:0] m_base [2];
  logic [5:0] m_off [2];
  int         start_cyc [2];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst) begin
      for (int v = 0; v < 2; v++) begin
        if (we_v[v]) begin
          dut_mem[v * 65536 + int'(wa_v[v])] = wd_v[v];
          dut_wr[v]++;
        end
      end
    end
  end

  function automatic bit guarded(int v, logic [12:0] a);
    return (v == 0) ? (a[12:11] == 2'b00) : (a[12:11] == 2'b11);
  endfunction

  function automatic logic [8:0] dut_look(int key);
    return dut_mem.exists(key) ? {1'b0, dut_mem[key]} : 9'h100;
  endfunction

  function automatic logic [8:0] exp_look(int key);
    return exp_mem.exists(key) ? {1'b0, exp_mem[key]} : 9'h100;
  endfunction

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic do_load(logic [12:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
    for (int v = 0; v < 2; v++) begin
      if (!m_busy[v]) begin
        m_base[v] = a[12:6]; m_off[v] = a[5:0];
        m_open[v] = 1; m_have[v] = 0; m_rej[v] = 0;
        for (int k = 0; k < 64; k++) m_val[v][k] = 0;
      end
    end
  endtask

  task automatic do_byte(logic [7:0] d, logic w, string tag);
    logic ev, eo;
    @(negedge clk); byte_stb = 1; byte_in = d; wp = w;
    @(negedge clk); byte_stb = 0;
    for (int v = 0; v < 2; v++) begin
      ev = 0; eo = 0;
      if (!m_busy[v] && m_open[v]) begin
        ev = 1;
        if (!m_have[v]) begin
          m_have[v] = 1;
          if (w && guarded(v, {m_base[v], m_off[v]})) m_rej[v] = 1;
        end
        eo = !m_rej[v];
        if (eo) begin
          m_buf[v][m_off[v]] = d; m_val[v][m_off[v]] = 1;
          m_off[v] = m_off[v] + 1;
        end
      end
      check($sformatf("R3 %s ack_vld v%0d", tag, v), ackv_v[v], ev);
      if (ev) check($sformatf("R3 R4 %s ack_ok v%0d", tag, v), acko_v[v], eo);
    end
  endtask

  task automatic do_commit(string tag);
    logic st;
    @(negedge clk); commit_req = 1;
    @(negedge clk); commit_req = 0;
    for (int v = 0; v < 2; v++) begin
      st = !m_busy[v] && m_open[v] && m_have[v] && !m_rej[v];
      if (!m_busy[v]) m_open[v] = 0;
      if (st) begin
        m_busy[v] = 1; start_cyc[v] = cyc;
        for (int k = 0; k < 64; k++) begin
          if (m_val[v][k]) begin
            exp_mem[v * 65536 + int'({m_base[v], 6'(k)})] = m_buf[v][k];
            exp_wr[v]++;
          end
        end
      end
      check($sformatf("R8 %s busy v%0d", tag, v), busy_v[v], m_busy[v]);
    end
  endtask

  task automatic wait_idle();
    bit seen [2];
    int n = 0;
    for (int v = 0; v < 2; v++) seen[v] = !m_busy[v];
    while (!(seen[0] && seen[1]) && n < 4 * WC) begin
      @(negedge clk); n++;
      for (int v = 0; v < 2; v++) begin
        if (!seen[v] && !busy_v[v]) begin
          check($sformatf("R8 busy length v%0d", v), cyc - start_cyc[v], WC);
          m_busy[v] = 0; seen[v] = 1;
        end
      end
    end
    for (int v = 0; v < 2; v++) begin
      if (!seen[v]) begin
        check("R8 busy never fell", 1, 0);
        m_busy[v] = 0;
      end
      check($sformatf("R9 write count v%0d", v), dut_wr[v], exp_wr[v]);
    end
  endtask

  task automatic check_page(logic [12:0] a);
    int bad;
    for (int v = 0; v < 2; v++) begin
      bad = 0;
      for (int k = 0; k < 64; k++) begin
        int key = v * 65536 + int'({a[12:6], 6'(k)});
        if (dut_look(key) !== exp_look(key)) bad++;
      end
      check($sformatf("R1 R2 R9 page %0h v%0d mismatches", a, v), bad, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [12:0] a;
    int n;
    seed = $urandom(32'd24681);
    for (int v = 0; v < 2; v++) begin
      m_open[v] = 0; m_have[v] = 0; m_rej[v] = 0; m_busy[v] = 0;
      m_base[v] = 0; m_off[v] = 0; dut_wr[v] = 0; exp_wr[v] = 0;
      for (int k = 0; k < 64; k++) m_val[v][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    for (int v = 0; v < 2; v++) begin
      check("reset busy", busy_v[v], 0);
      check("reset ack_vld", ackv_v[v], 0);
      check("reset ram_we", we_v[v], 0);
    end
    // R3: strobe with no open transaction
    do_byte(8'h11, 0, "no txn");
    // R7: dummy write without data
    do_load(13'h0123);
    do_commit("R7 empty");
    // R4 R6: bottom quarter guarded only in variant 0
    do_load(13'h0040);
    do_byte(8'hA1, 1, "R6 low first");
    do_byte(8'hA2, 0, "R6 low later");
    do_commit("R6 low");
    wait_idle(); check_page(13'h0040);
    // R4 R6: top quarter guarded only in variant 1
    do_load(13'h1FC0);
    do_byte(8'hB1, 1, "R6 high first");
    do_byte(8'hB2, 1, "R6 high later");
    do_commit("R6 high");
    wait_idle(); check_page(13'h1FC0);
    // R5: wp rising after the first byte has no effect
    do_load(13'h0090);
    do_byte(8'hC1, 0, "R5 first");
    do_byte(8'hC2, 1, "R5 later");
    do_byte(8'hC3, 1, "R5 later");
    do_commit("R5");
    wait_idle(); check_page(13'h0090);
    // R2: wrap inside the page with overwrite
    do_load(13'h0A3E);
    for (int i = 0; i < 70; i++) do_byte(8'(i * 3 + 1), 0, "R2 wrap");
    do_commit("R2 wrap");
    wait_idle(); check_page(13'h0A3E);
    // R10: inputs ignored while busy; R8: transaction closed after commit
    do_load(13'h0C05);
    do_byte(8'hD1, 0, "R10 setup");
    do_byte(8'hD2, 0, "R10 setup");
    do_commit("R10 setup");
    do_load(13'h0D00);
    do_byte(8'hEE, 0, "R10 busy");
    do_commit("R10 busy");
    wait_idle(); check_page(13'h0C05); check_page(13'h0D00);
    do_commit("R8 second");
    wait_idle();
    // random transactions
    for (int t = 0; t < 30; t++) begin
      a = 13'($urandom);
      n = int'($urandom % 72);
      do_load(a);
      for (int i = 0; i < n; i++) do_byte(8'($urandom), 1'($urandom), "rand");
      do_commit("rand");
      wait_idle(); check_page(a);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule